// File: doc/BRIEF.md
# Floppy Seek-Step Sequencer

This block is the head-positioning engine inside a floppy disk controller. It runs five motion commands: restore to track zero, seek to a target track, a plain step, a step toward higher track numbers, and a step toward lower track numbers. A host register file hands it one command byte together with the current track and data register values. The block then drives the step and direction pins of the drive, watches the index and track-zero inputs, and keeps the busy, data-request, CRC-error, seek-error and interrupt flags. The updated track and data register values are returned to the register file.

Commands enter through a valid/ready channel. `cmd_ready` is high only while the sequencer is idle. A command, `track_in` and `data_in` transfer together on a clock edge where `cmd_valid` and `cmd_ready` are both high. While the sequencer is busy the host must hold the command pending, and the sequencer exerts back-pressure until it returns to idle.

A command can first wait for the spindle to spin up, which takes six index pulses. When the command asks for verification, the block hands off to an external ID-field verifier by raising a one-cycle start pulse and then waiting for a done/ok reply. Settling time after each step comes from a two-bit rate field and is counted in prescaled ticks.

Top module: `fdc_seek_seq`

## Requirements
- R1: `cmd_ready` is high only when the sequencer is idle and `busy` is low. Accepting a motion command (bit 7 = 0) sets `busy` and clears `irq`, `drq`, `crc_err` and `seek_err` at the same edge.
- R2: Restore (bits 7..4 = 0000) loads the track register with all ones and the data register with 0, then steps outward (`dir_out` = 0) one track per pulse. When `trk0_in` is high at a track comparison, the track register is loaded with 0 and motion ends, and this holds even before the first pulse.
- R3: A restore that has issued MAX_STEPS (255) pulses without seeing `trk0_in` stops and sets `seek_err`. No more than MAX_STEPS pulses are issued per command.
- R4: Seek (bits 7..4 = 0001) steps the track register one track per pulse toward `data_in` until the two are equal, and ends with `track_out` equal to the target. When the two are already equal, no pulse is issued.
- R5: `dir_out` = 1 means inward, with the track number increasing. Step-in (bits 7..5 = 010) sets it to 1, step-out (011) sets it to 0, and a plain step (001) keeps the direction left by the previous command.
- R6: Single-step commands issue exactly one pulse. With u (bit 4) = 1 the track register moves by one in the current direction. With u = 0 the track register is unchanged.
- R7: With h (bit 3) = 1, no step pulse is issued until six rising edges of `index_in` have been seen since the command was accepted.
- R8: With v (bit 2) = 1, `verify_start` is high for exactly one cycle after the motion ends, and the block then waits for `verify_done`. If `verify_ok` is low at that point, `seek_err` is set. A restore that ends in the step-limit error skips verification.
- R9: On completion the block sets `irq`, clears `busy` and returns to idle. No step pulse and no `verify_start` occur while idle.
- R10: Each step pulse is high for exactly STEP_CLKS cycles, and `dir_out` is stable while the pulse is high.
- R11: Between successive step pulses of one command there are at least STEP_CLKS + T×CLK_PER_TICK cycles from rising edge to rising edge, where T is 6, 12, 20 or 30 for rate field (bits 1..0) values 0, 1, 2 or 3.
- R12: A `drq_set` or `crc_set` pulse sets `drq` or `crc_err` respectively. Accepting a motion command clears both flags.
- R13: A command with bit 7 set is consumed, but it leaves `busy`, `irq`, `track_out` and `cmd_ready` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command will be taken |
| cmd_data | input | 8 | Command byte |
| track_in | input | REG_W | Track register value sampled with the command |
| data_in | input | REG_W | Data register value (target) sampled with the command |
| track_out | output | REG_W | Current track register |
| data_out | output | REG_W | Current data register |
| step_out | output | 1 | Step pulse to the drive |
| dir_out | output | 1 | Step direction, 1 = inward |
| index_in | input | 1 | Index pulse from the drive |
| trk0_in | input | 1 | Head at track zero |
| verify_start | output | 1 | One-cycle start to the ID verifier |
| verify_done | input | 1 | Verifier finished |
| verify_ok | input | 1 | Verifier found a matching ID |
| drq_set | input | 1 | Data-request set pulse from the transfer engine |
| crc_set | input | 1 | CRC-error set pulse from the transfer engine |
| busy | output | 1 | Command in progress |
| drq | output | 1 | Data-request flag |
| crc_err | output | 1 | CRC-error flag |
| seek_err | output | 1 | Seek or verify failure |
| irq | output | 1 | Command-complete interrupt |

## Verification
The assertions take for granted that `index_in` is a clean level signal whose rising edges mark pulses. They also assume `verify_done` is asserted only while the sequencer waits after its own `verify_start`, and that command bytes are offered only through the valid/ready handshake. The bench keeps to these rules. It waits for `cmd_ready` before raising `cmd_valid` for a single transfer. Its verifier model answers only a seen `verify_start`, a few cycles later. Index pulses are driven as separated high phases, and track zero is raised only after a chosen number of observed pulses.

// File: rtl/fdc_seek_pkg.sv
package fdc_seek_pkg;

  typedef enum logic [2:0] {
    OP_RESTORE,
    OP_SEEK,
    OP_STEP,
    OP_STEP_IN,
    OP_STEP_OUT
  } op_e;

  typedef struct packed {
    op_e        op;
    logic       upd;
    logic       spin;
    logic       verify;
    logic [1:0] rate;
  } cmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SPIN,
    ST_DECODE,
    ST_CMP,
    ST_UPDATE,
    ST_PULSE,
    ST_SETTLE,
    ST_VCHK,
    ST_VSTART,
    ST_VWAIT,
    ST_FINISH
  } state_e;

  localparam int SETTLE_W = 5;

  // settle length in prescaled ticks for each rate code
  function automatic logic [SETTLE_W-1:0] settle_ticks(input logic [1:0] rate);
    case (rate)
      2'd0:    settle_ticks = 5'd6;
      2'd1:    settle_ticks = 5'd12;
      2'd2:    settle_ticks = 5'd20;
      default: settle_ticks = 5'd30;
    endcase
  endfunction

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_seek_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output cmd_t       fields,
  output logic       motion_cmd
);

  always_comb begin
    motion_cmd    = ~cmd_byte[7];
    fields.upd    = cmd_byte[4];
    fields.spin   = cmd_byte[3];
    fields.verify = cmd_byte[2];
    fields.rate   = cmd_byte[1:0];
    case (cmd_byte[6:4])
      3'b000:         fields.op = OP_RESTORE;
      3'b001:         fields.op = OP_SEEK;
      3'b010, 3'b011: fields.op = OP_STEP;
      3'b100, 3'b101: fields.op = OP_STEP_IN;
      default:        fields.op = OP_STEP_OUT;
    endcase
  end

endmodule

// File: rtl/fdc_delay.sv
module fdc_delay #(
  parameter int CLK_PER_TICK = 8,
  parameter int LEN_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_tick,
  input  logic [LEN_W-1:0] len,
  output logic             done
);

  logic             tick;
  logic             active;
  logic             unit_r;
  logic             adv;
  logic [LEN_W-1:0] remain;

  generate
    if (CLK_PER_TICK <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_prescale
      localparam int PW = $clog2(CLK_PER_TICK);
      localparam logic [PW-1:0] PMAX = PW'(CLK_PER_TICK - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pre <= '0;
        else if (start || pre == PMAX) pre <= '0;
        else                          pre <= pre + 1'b1;
      end
      assign tick = (pre == PMAX);
    end
  endgenerate

  assign adv  = unit_r ? tick : 1'b1;
  assign done = active && adv && (remain == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      unit_r <= 1'b0;
      remain <= '0;
    end else if (start) begin
      active <= 1'b1;
      unit_r <= use_tick;
      remain <= len;
    end else if (done) begin
      active <= 1'b0;
    end else if (active && adv) begin
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/fdc_index_wait.sv
module fdc_index_wait #(
  parameter int SPIN_PULSES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic index_in,
  output logic reached
);

  localparam int CW = $clog2(SPIN_PULSES + 1);
  localparam logic [CW-1:0] CMAX = CW'(SPIN_PULSES);

  logic [CW-1:0] cnt;
  logic          idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 1'b0;
      cnt   <= '0;
    end else begin
      idx_q <= index_in;
      if (clear)                                    cnt <= '0;
      else if (index_in && !idx_q && cnt != CMAX)   cnt <= cnt + 1'b1;
    end
  end

  assign reached = (cnt == CMAX);

endmodule

// File: rtl/fdc_seek_seq.sv
module fdc_seek_seq
  import fdc_seek_pkg::*;
#(
  parameter int REG_W        = 8,
  parameter int CLK_PER_TICK = 500,
  parameter int STEP_CLKS    = 32,
  parameter int MAX_STEPS    = 255,
  parameter int SPIN_PULSES  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_data,
  input  logic [REG_W-1:0] track_in,
  input  logic [REG_W-1:0] data_in,
  output logic [REG_W-1:0] track_out,
  output logic [REG_W-1:0] data_out,
  output logic             step_out,
  output logic             dir_out,
  input  logic             index_in,
  input  logic             trk0_in,
  output logic             verify_start,
  input  logic             verify_done,
  input  logic             verify_ok,
  input  logic             drq_set,
  input  logic             crc_set,
  output logic             busy,
  output logic             drq,
  output logic             crc_err,
  output logic             seek_err,
  output logic             irq
);

  localparam int STEP_W = $clog2(STEP_CLKS + 1);
  localparam int LEN_W  = (STEP_W > SETTLE_W) ? STEP_W : SETTLE_W;
  localparam int SC_W   = $clog2(MAX_STEPS + 1);
  localparam logic [SC_W-1:0] SC_MAX = SC_W'(MAX_STEPS);

  state_e           state, state_n;
  cmd_t             dec, cmd_r;
  logic             motion_cmd;
  logic             accept;
  logic             seek_like;
  logic             is_restore;
  logic [REG_W-1:0] track_r, data_r;
  logic             dir_r;
  logic [SC_W-1:0]  step_cnt;
  logic             spin_done;
  logic             dly_start, dly_unit, dly_done;
  logic [LEN_W-1:0] dly_len;

  fdc_cmd_decode u_dec (
    .cmd_byte   (cmd_data),
    .fields     (dec),
    .motion_cmd (motion_cmd)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready && motion_cmd;

  fdc_index_wait #(.SPIN_PULSES(SPIN_PULSES)) u_spin (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .index_in (index_in),
    .reached  (spin_done)
  );

  assign is_restore = (cmd_r.op == OP_RESTORE);
  assign seek_like  = (cmd_r.op == OP_RESTORE) || (cmd_r.op == OP_SEEK);

  // next-state logic
  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:   if (accept) state_n = dec.spin ? ST_SPIN : ST_DECODE;
      ST_SPIN:   if (spin_done) state_n = ST_DECODE;
      ST_DECODE: begin
        if (seek_like)      state_n = ST_CMP;
        else if (cmd_r.upd) state_n = ST_UPDATE;
        else                state_n = ST_PULSE;
      end
      ST_CMP: begin
        if (is_restore && trk0_in)                   state_n = ST_VCHK;
        else if (is_restore && step_cnt == SC_MAX)   state_n = ST_FINISH;
        else if (track_r == data_r)                  state_n = ST_VCHK;
        else                                         state_n = ST_UPDATE;
      end
      ST_UPDATE: state_n = ST_PULSE;
      ST_PULSE:  if (dly_done) state_n = ST_SETTLE;
      ST_SETTLE: if (dly_done) state_n = seek_like ? ST_CMP : ST_VCHK;
      ST_VCHK:   state_n = cmd_r.verify ? ST_VSTART : ST_FINISH;
      ST_VSTART: state_n = ST_VWAIT;
      ST_VWAIT:  if (verify_done) state_n = ST_FINISH;
      ST_FINISH: state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  // timer launch on entry to pulse or settle
  always_comb begin
    dly_start = (state_n != state) && (state_n == ST_PULSE || state_n == ST_SETTLE);
    dly_unit  = (state_n == ST_SETTLE);
    if (state_n == ST_SETTLE) dly_len = LEN_W'(settle_ticks(cmd_r.rate));
    else                      dly_len = LEN_W'(STEP_CLKS);
  end

  fdc_delay #(.CLK_PER_TICK(CLK_PER_TICK), .LEN_W(LEN_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dly_start),
    .use_tick (dly_unit),
    .len      (dly_len),
    .done     (dly_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  // command register and register file shadow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_r    <= '0;
      track_r  <= '0;
      data_r   <= '0;
      dir_r    <= 1'b0;
      step_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cmd_r    <= dec;
            track_r  <= track_in;
            data_r   <= data_in;
            step_cnt <= '0;
          end
        end
        ST_DECODE: begin
          if (cmd_r.op == OP_RESTORE) begin
            track_r <= '1;
            data_r  <= '0;
          end
          if (cmd_r.op == OP_STEP_IN)  dir_r <= 1'b1;
          if (cmd_r.op == OP_STEP_OUT) dir_r <= 1'b0;
        end
        ST_CMP: begin
          if (is_restore && trk0_in)              track_r <= '0;
          else if (is_restore && step_cnt == SC_MAX) begin
            // limit reached, leave registers as they are
          end else if (track_r != data_r)         dir_r <= (data_r > track_r);
        end
        ST_UPDATE: begin
          if (dir_r) track_r <= track_r + 1'b1;
          else       track_r <= track_r - 1'b1;
        end
        ST_PULSE: begin
          if (dly_done && step_cnt != SC_MAX) step_cnt <= step_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      drq      <= 1'b0;
      crc_err  <= 1'b0;
      seek_err <= 1'b0;
      irq      <= 1'b0;
    end else if (accept) begin
      busy     <= 1'b1;
      drq      <= 1'b0;
      crc_err  <= 1'b0;
      seek_err <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (drq_set) drq     <= 1'b1;
      if (crc_set) crc_err <= 1'b1;
      if (state == ST_CMP && is_restore && !trk0_in && step_cnt == SC_MAX)
        seek_err <= 1'b1;
      if (state == ST_VWAIT && verify_done && !verify_ok)
        seek_err <= 1'b1;
      if (state == ST_FINISH) begin
        irq  <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  assign track_out    = track_r;
  assign data_out     = data_r;
  assign dir_out      = dir_r;
  assign step_out     = (state == ST_PULSE);
  assign verify_start = (state == ST_VSTART);

endmodule

// File: rtl/fdc_seek_seq_chk.sv
module fdc_seek_seq_chk #(
  parameter int STEP_CLKS   = 32,
  parameter int MAX_STEPS   = 255,
  parameter int SPIN_PULSES = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_data,
  input logic       step_out,
  input logic       dir_out,
  input logic       index_in,
  input logic       verify_start,
  input logic       busy,
  input logic       drq,
  input logic       crc_err,
  input logic       irq
);

  localparam int HW = $clog2(STEP_CLKS + 2);
  localparam int NW = $clog2(MAX_STEPS + 2);
  localparam int IW = $clog2(SPIN_PULSES + 1);

  logic          acc_motion;
  logic [HW-1:0] hi_cnt;
  logic [NW-1:0] n_steps;
  logic [IW-1:0] idx_cnt;
  logic          idx_q, step_q, spin_cmd;

  assign acc_motion = cmd_valid && cmd_ready && !cmd_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      n_steps  <= '0;
      idx_cnt  <= '0;
      idx_q    <= 1'b0;
      step_q   <= 1'b0;
      spin_cmd <= 1'b0;
    end else begin
      idx_q  <= index_in;
      step_q <= step_out;
      if (step_out && hi_cnt != HW'(STEP_CLKS + 1)) hi_cnt <= hi_cnt + 1'b1;
      else if (!step_out)                           hi_cnt <= '0;
      if (acc_motion) begin
        spin_cmd <= cmd_data[3];
        idx_cnt  <= '0;
        n_steps  <= '0;
      end else begin
        if (index_in && !idx_q && idx_cnt != IW'(SPIN_PULSES)) idx_cnt <= idx_cnt + 1'b1;
        if (step_out && !step_q && n_steps != NW'(MAX_STEPS + 1)) n_steps <= n_steps + 1'b1;
      end
    end
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy); // R1
  AST_ACCEPT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_motion |=> (busy && !irq && !drq && !crc_err)); // R1
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    n_steps <= NW'(MAX_STEPS)); // R3
  AST_SPIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_out && !step_q && spin_cmd) |-> (idx_cnt == IW'(SPIN_PULSES))); // R7
  AST_VSTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    verify_start |=> !verify_start); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!step_out && !verify_start)); // R9
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy); // R9
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    step_out |-> (hi_cnt < HW'(STEP_CLKS))); // R10
  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_out && step_q) |-> (hi_cnt == HW'(STEP_CLKS))); // R10
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_out && step_q) |-> $stable(dir_out)); // R10
  AST_UPPER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_data[7]) |=> (cmd_ready && !busy)); // R13

endmodule

bind fdc_seek_seq fdc_seek_seq_chk #(
  .STEP_CLKS   (STEP_CLKS),
  .MAX_STEPS   (MAX_STEPS),
  .SPIN_PULSES (SPIN_PULSES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_data     (cmd_data),
  .step_out     (step_out),
  .dir_out      (dir_out),
  .index_in     (index_in),
  .verify_start (verify_start),
  .busy         (busy),
  .drq          (drq),
  .crc_err      (crc_err),
  .irq          (irq)
);

// File: tb/fdc_seek_seq_tb.sv
module fdc_seek_seq_tb;

  localparam int CPT  = 2;
  localparam int SCLK = 3;

  typedef struct {
    string    req;
    int       trk;
    int       dat;
    int       steps;
    int       dir;
    int       serr;
    int       vst;
    int       gap;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = '0;
  logic [7:0] track_in = '0, data_in = '0;
  logic [7:0] track_out, data_out;
  logic       step_out, dir_out;
  logic       index_in = 1'b0;
  logic       trk0_in = 1'b0;
  logic       verify_start;
  logic       verify_done = 1'b0, verify_ok = 1'b0;
  logic       drq_set = 1'b0, crc_set = 1'b0;
  logic       busy, drq, crc_err, seek_err, irq;

  fdc_seek_seq #(.CLK_PER_TICK(CPT), .STEP_CLKS(SCLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .track_in(track_in), .data_in(data_in),
    .track_out(track_out), .data_out(data_out), .step_out(step_out),
    .dir_out(dir_out), .index_in(index_in), .trk0_in(trk0_in),
    .verify_start(verify_start), .verify_done(verify_done), .verify_ok(verify_ok),
    .drq_set(drq_set), .crc_set(crc_set), .busy(busy), .drq(drq),
    .crc_err(crc_err), .seek_err(seek_err), .irq(irq)
  );

  always #5 clk = ~clk;

  int   checks = 0, errors = 0;
  exp_t q[$];
  int   done_cnt = 0;
  int   step_seen = 0, vst_seen = 0, hi = 0, since = 0, min_gap = 0;
  int   trk0_at = -1;
  logic vok = 1'b1;
  logic busy_q = 1'b0, step_q = 1'b0, irq_q = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int settle(input int rate);
    case (rate)
      0: return 6;
      1: return 12;
      2: return 20;
      default: return 30;
    endcase
  endfunction

  function automatic exp_t mk(input string req, input int trk, input int dat, input int steps,
                              input int dir, input int serr, input int vst, input int rate);
    exp_t e;
    e.req = req; e.trk = trk; e.dat = dat; e.steps = steps; e.dir = dir;
    e.serr = serr; e.vst = vst; e.gap = SCLK + settle(rate) * CPT;
    return e;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !busy_q) begin
        step_seen = 0; vst_seen = 0; since = 0; min_gap = 1000000; hi = 0;
      end
      since++;
      if (step_out && !step_q) begin
        if (step_seen > 0 && since < min_gap) min_gap = since;
        since = 0;
        step_seen++;
      end
      if (step_out) hi++;
      else if (step_q) begin
        check("R10 pulse width", hi, SCLK);
        hi = 0;
      end
      if (verify_start) vst_seen++;
      trk0_in = (trk0_at >= 0) && (step_seen >= trk0_at);
      if (irq && !irq_q) begin
        if (q.size() == 0) check("scoreboard empty", 0, 1);
        else begin
          exp_t e;
          e = q.pop_front();
          check({e.req, " track"}, int'(track_out), e.trk);
          check({e.req, " data"}, int'(data_out), e.dat);
          check({e.req, " steps"}, step_seen, e.steps);
          check({e.req, " R5 dir"}, int'(dir_out), e.dir);
          check({e.req, " seek_err"}, int'(seek_err), e.serr);
          check({e.req, " R8 vstart"}, vst_seen, e.vst);
          check("R9 done idle", int'({busy, cmd_ready}), 1);
          if (e.steps >= 2) check({e.req, " R11 gap"}, int'(min_gap >= e.gap), 1);
        end
        done_cnt++;
      end
      busy_q = busy; step_q = step_out; irq_q = irq;
    end
  end

  // verifier model
  initial begin
    forever begin
      @(negedge clk);
      if (verify_start) begin
        repeat (3) @(negedge clk);
        verify_ok = vok;
        verify_done = 1'b1;
        @(negedge clk);
        verify_done = 1'b0;
      end
    end
  end

  task automatic issue(input logic [7:0] c, input logic [7:0] t, input logic [7:0] d, input exp_t e);
    int target;
    target = done_cnt + 1;
    q.push_back(e);
    forever begin
      @(negedge clk);
      if (cmd_ready) break;
    end
    cmd_valid = 1'b1; cmd_data = c; track_in = t; data_in = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1 R12 accept flags", int'({busy, irq, drq, crc_err, cmd_ready}), 5'b10000);
    wait (done_cnt == target);
  endtask

  task automatic idx_pulse();
    @(negedge clk); index_in = 1'b1;
    repeat (2) @(negedge clk);
    index_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", int'(cmd_ready), 1);
    check("R9 reset status", int'({busy, irq, seek_err, step_out, verify_start}), 0);
    check("reset regs", int'({track_out, data_out}), 0);

    // restore meets track zero after 3 pulses
    trk0_at = 3;
    issue(8'h00, 8'h50, 8'h33, mk("R2 restore", 0, 0, 3, 0, 0, 0, 0));
    // restore already at track zero
    trk0_at = 0;
    issue(8'h00, 8'h20, 8'h10, mk("R2 restore at zero", 0, 0, 0, 0, 0, 0, 0));
    trk0_at = -1;

    // status set pulses, then cleared by accept
    @(negedge clk); drq_set = 1'b1; crc_set = 1'b1;
    @(negedge clk); drq_set = 1'b0; crc_set = 1'b0;
    @(negedge clk);
    check("R12 flags set", int'({drq, crc_err}), 3);

    issue(8'h11, 8'd10, 8'd13, mk("R4 seek in", 13, 13, 3, 1, 0, 0, 1));
    issue(8'h13, 8'd7, 8'd4, mk("R4 seek out", 4, 4, 3, 0, 0, 0, 3));
    issue(8'h10, 8'd9, 8'd9, mk("R4 seek equal", 9, 9, 0, 0, 0, 0, 0));
    issue(8'h50, 8'd20, 8'd0, mk("R6 step-in u", 21, 0, 1, 1, 0, 0, 0));
    issue(8'h60, 8'd20, 8'd0, mk("R6 step-out no u", 20, 0, 1, 0, 0, 0, 0));
    issue(8'h30, 8'd20, 8'd0, mk("R5 step keeps out", 19, 0, 1, 0, 0, 0, 0));
    issue(8'h40, 8'd5, 8'd0, mk("R6 step-in no u", 5, 0, 1, 1, 0, 0, 0));
    issue(8'h20, 8'd5, 8'd0, mk("R5 step keeps in", 5, 0, 1, 1, 0, 0, 0));

    vok = 1'b1;
    issue(8'h14, 8'd2, 8'd4, mk("R8 verify ok", 4, 4, 2, 1, 0, 1, 0));
    vok = 1'b0;
    issue(8'h14, 8'd4, 8'd4, mk("R8 verify bad", 4, 4, 0, 1, 1, 1, 0));
    vok = 1'b1;

    issue(8'h04, 8'd3, 8'd3, mk("R3 restore limit", 0, 0, 255, 0, 1, 0, 0));

    // spin-up wait
    fork
      issue(8'h18, 8'd1, 8'd2, mk("R7 spin seek", 2, 2, 1, 1, 0, 0, 0));
      begin
        wait (busy);
        repeat (5) idx_pulse();
        repeat (40) @(negedge clk);
        check("R7 no step before six", step_seen, 0);
        check("R7 still busy", int'(busy), 1);
        idx_pulse();
      end
    join

    // command with bit 7 set is consumed and ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = 8'h80; track_in = 8'd99; data_in = 8'd77;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R13 busy", int'(busy), 0);
    check("R13 irq kept", int'(irq), 1);
    check("R13 track kept", int'(track_out), 2);
    check("R13 ready", int'(cmd_ready), 1);

    check("scoreboard drained", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule